// File: doc/BRIEF.md
# Paired Burst Store Sequencer

This block performs a double store. One go strobe, with a translated start address and a 36-bit operand, makes it write the same value into two data-memory words on back-to-back clock cycles. The intended use is clearing a memory page twice as fast as with single-word stores.

The partner address is formed burst-style inside the aligned group of four words that holds the start address. For start offsets 0, 1 and 2 inside the group, the partner is the next word. For offset 3, the partner wraps back to the first word of the group.

The stored value is the bit transpose of the operand. An all-zero fill is therefore written unchanged. A start address with its top bit set marks a write-protected page: the sequence still runs to completion, but no write enable is raised. The block has no flag outputs and leaves processor state alone.

Top module: `dss_burst_store`

## Requirements
- R1: While reset is held and in the cycle after it is released, `mem_we_o`, `done_o` and `busy_o` are all low.
- R2: A go strobe sampled while idle puts the start address on `mem_addr_o` in the next cycle, and the partner address in the cycle after that.
- R3: When the start address mod 4 is 0, 1 or 2, the partner address is the start address plus one.
- R4: When the start address mod 4 is 3, the partner address is the start address minus three, so bits above bit 1 never change.
- R5: Both writes carry the transpose of the operand. The operand is read as six groups of six bits, and operand bit 6g+p lands at written bit 6p+g.
- R6: If bit 35 of the start address is set, `mem_we_o` stays low in both write cycles, and the done pulse still occurs at its normal time.
- R7: `done_o` is high for exactly one cycle, the cycle after the second write. `busy_o` is high from the first write cycle through the done cycle and low the cycle after.
- R8: A go strobe sampled while `busy_o` is high is ignored: no extra writes occur and the address in flight is unchanged.
- R9: Issuing 2048 operations at stride two across a 4096-word page with a zero operand clears every word of that page and writes no word outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Start strobe, sampled when idle |
| addr_i | input | 36 | Translated start address; bit 35 set means write-protected |
| operand_i | input | 36 | Value to be transposed and stored |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 36 | Memory write address |
| mem_wdata_o | output | 36 | Memory write data (transposed operand) |

## Verification
The hardest situation to bring about is a go strobe that arrives while an operation is in flight, because it must land precisely in the write cycles. The stimulus holds go high, with a different address, through both write cycles and drops it on the done cycle. The bench then confirms that only the original pair was written and that nothing follows. The wrap case is reached by sweeping the low three address bits under several operand patterns. A whole-page clear run against a prefilled memory model shows that no word outside the page was disturbed.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_DONE   = 2'd3
  } dss_state_e;
endpackage

// File: rtl/dss_transpose.sv
// Square bit transpose: word viewed as GRP groups of GRP bits.
module dss_transpose #(
  parameter int GRP = 6,
  localparam int DW = GRP * GRP
) (
  input  logic [DW-1:0] in_word,
  output logic [DW-1:0] out_word
);
  for (genvar g = 0; g < GRP; g++) begin : g_grp
    for (genvar p = 0; p < GRP; p++) begin : g_pos
      assign out_word[p*GRP+g] = in_word[g*GRP+p];
    end
  end
endmodule

// File: rtl/dss_pair_addr.sv
// Partner address: increments the burst field modulo its size, upper bits held.
module dss_pair_addr #(
  parameter int AW         = 36,
  parameter int BURST_LOG2 = 2
) (
  input  logic [AW-1:0] base_addr,
  output logic [AW-1:0] pair_addr
);
  logic [BURST_LOG2-1:0] low_next;
  assign low_next  = base_addr[BURST_LOG2-1:0] + BURST_LOG2'(1);
  assign pair_addr = {base_addr[AW-1:BURST_LOG2], low_next};
endmodule

// File: rtl/dss_ctrl.sv
module dss_ctrl
  import dss_pkg::*;
#(
  parameter int AW       = 36,
  parameter int DW       = 36,
  parameter int PROT_BIT = AW - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [AW-1:0] pair_addr_i,
  output logic [AW-1:0] addr_q_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o
);
  dss_state_e state_q;
  logic [AW-1:0] addr_q;

  assign addr_q_o = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      we_o    <= 1'b0;
      waddr_o <= '0;
      wdata_o <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          done_o <= 1'b0;
          if (go_i) begin
            addr_q  <= addr_i;
            waddr_o <= addr_i;
            wdata_o <= data_i;
            we_o    <= ~addr_i[PROT_BIT];
            busy_o  <= 1'b1;
            state_q <= ST_FIRST;
          end
        end
        ST_FIRST: begin
          waddr_o <= pair_addr_i;
          we_o    <= ~addr_q[PROT_BIT];
          state_q <= ST_SECOND;
        end
        ST_SECOND: begin
          we_o    <= 1'b0;
          done_o  <= 1'b1;
          state_q <= ST_DONE;
        end
        ST_DONE: begin
          done_o  <= 1'b0;
          busy_o  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dss_burst_store.sv
module dss_burst_store #(
  parameter int GRP        = 6,
  parameter int AW         = 36,
  parameter int BURST_LOG2 = 2,
  localparam int DW        = GRP * GRP,
  localparam int PROT_BIT  = AW - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] operand_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o
);
  logic [DW-1:0] xposed;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] pair_addr;

  dss_transpose #(.GRP(GRP)) u_xpose (
    .in_word (operand_i),
    .out_word(xposed)
  );

  dss_pair_addr #(.AW(AW), .BURST_LOG2(BURST_LOG2)) u_pair (
    .base_addr(addr_q),
    .pair_addr(pair_addr)
  );

  dss_ctrl #(.AW(AW), .DW(DW), .PROT_BIT(PROT_BIT)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .go_i       (go_i),
    .addr_i     (addr_i),
    .data_i     (xposed),
    .pair_addr_i(pair_addr),
    .addr_q_o   (addr_q),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .we_o       (mem_we_o),
    .waddr_o    (mem_addr_o),
    .wdata_o    (mem_wdata_o)
  );
endmodule

// File: rtl/dss_checker.sv
module dss_checker #(
  parameter int AW = 36,
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o
);
  AST_PROT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> !mem_addr_o[AW-1]); // R6

  AST_PAIR_IN_GROUP: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && $past(mem_we_o)) |->
      (mem_addr_o[AW-1:2] == $past(mem_addr_o[AW-1:2]) &&
       mem_addr_o[1:0] == $past(mem_addr_o[1:0]) + 2'd1)); // R4

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && $past(mem_we_o)) |-> $stable(mem_wdata_o)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!mem_we_o && busy_o)); // R7

  AST_WE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> busy_o); // R2
endmodule

bind dss_burst_store dss_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o)
);

// File: tb/sim_dss_burst_store.sv
`timescale 1ns/1ps
module sim_dss_burst_store;
  localparam int MEMW = 16384;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        go_i = 1'b0;
  logic [35:0] addr_i = '0;
  logic [35:0] operand_i = '0;
  logic        busy_o, done_o, mem_we_o;
  logic [35:0] mem_addr_o, mem_wdata_o;

  int checks = 0;
  int errors = 0;
  int oor = 0;
  int cycles = 0;
  logic [35:0] mem [MEMW];

  dss_burst_store u0 (
    .clk(clk), .rst(rst), .go_i(go_i), .addr_i(addr_i), .operand_i(operand_i),
    .busy_o(busy_o), .done_o(done_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired act=%0d exp<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] xpose(input logic [35:0] v);
    logic [35:0] r;
    for (int g = 0; g < 6; g++)
      for (int p = 0; p < 6; p++)
        r[p*6+g] = v[g*6+p];
    return r;
  endfunction

  function automatic logic [35:0] partner(input logic [35:0] a);
    return (a % 4 == 3) ? a - 36'd3 : a + 36'd1;
  endfunction

  task automatic mem_update();
    if (mem_we_o) begin
      if (mem_addr_o[35:14] != 0) oor++;
      else mem[mem_addr_o[13:0]] = mem_wdata_o;
    end
  endtask

  task automatic run_op(input logic [35:0] a, input logic [35:0] op, input bit do_chk, input bit poke);
    logic exp_we;
    logic [35:0] exp_d;
    exp_we = ~a[35];
    exp_d  = xpose(op);
    @(negedge clk);
    go_i = 1'b1; addr_i = a; operand_i = op;
    @(negedge clk); // first write cycle
    if (poke) addr_i = a ^ 36'h400; else go_i = 1'b0;
    mem_update();
    if (do_chk) begin
      chk(mem_we_o == exp_we, a[35] ? "R6 first we" : "R2 first we", 64'(mem_we_o), 64'(exp_we));
      chk(mem_addr_o == a, "R2 first addr", 64'(mem_addr_o), 64'(a));
      chk(mem_wdata_o == exp_d, "R5 first data", 64'(mem_wdata_o), 64'(exp_d));
      chk(busy_o && !done_o, "R7 busy in first", 64'({busy_o, done_o}), 64'b10);
    end
    @(negedge clk); // second write cycle
    mem_update();
    if (do_chk) begin
      chk(mem_we_o == exp_we, a[35] ? "R6 second we" : "R2 second we", 64'(mem_we_o), 64'(exp_we));
      chk(mem_addr_o == partner(a), (a % 4 == 3) ? "R4 wrap addr" : "R3 next addr",
          64'(mem_addr_o), 64'(partner(a)));
      chk(mem_wdata_o == exp_d, "R5 second data", 64'(mem_wdata_o), 64'(exp_d));
    end
    go_i = 1'b0;
    @(negedge clk); // done cycle
    mem_update();
    if (do_chk)
      chk(done_o && busy_o && !mem_we_o, "R7 done cycle", 64'({done_o, busy_o, mem_we_o}), 64'b110);
    @(negedge clk);
    mem_update();
    if (do_chk)
      chk(!done_o && !busy_o && !mem_we_o, "R7 idle after done", 64'({done_o, busy_o, mem_we_o}), 64'b000);
  endtask

  initial begin
    logic [35:0] pats [4];
    int bad_in, bad_out, extra;
    pats[0] = 36'h0;
    pats[1] = 36'hFFFFFFFFF;
    pats[2] = 36'h123456789;
    pats[3] = 36'h00000003F;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!mem_we_o && !done_o && !busy_o, "R1 during reset", 64'({mem_we_o, done_o, busy_o}), 64'b0);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_we_o && !done_o && !busy_o, "R1 after release", 64'({mem_we_o, done_o, busy_o}), 64'b0);

    // R2 R3 R4 R5: sweep low address bits and operand patterns
    for (int lo = 0; lo < 8; lo++)
      for (int pi = 0; pi < 4; pi++)
        run_op(36'h0_9ABC_DE0 + 36'(lo), pats[pi], 1'b1, 1'b0);
    for (int lo = 0; lo < 4; lo++)
      run_op(36'h7_FFFF_FFC + 36'(lo), 36'h0A5A5A5A5, 1'b1, 1'b0);

    // R6: protected start addresses
    for (int lo = 0; lo < 4; lo++)
      run_op(36'h8_0000_1000 + 36'(lo), pats[2], 1'b1, 1'b0);

    // R8: go held with a different address through the busy window
    oor = 0;
    for (int i = 0; i < MEMW; i++) mem[i] = 36'h111;
    run_op(36'h0_0000_0203, 36'h0, 1'b1, 1'b1);
    extra = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (mem_we_o) extra++;
    end
    chk(extra == 0, "R8 no extra writes", 64'(extra), 64'd0);
    bad_out = 0;
    for (int i = 0; i < MEMW; i++)
      if (mem[i] != ((i == 'h203 || i == 'h200) ? 36'h0 : 36'h111)) bad_out++;
    chk(bad_out == 0, "R8 only pair written", 64'(bad_out), 64'd0);

    // R9: full page clear at stride two
    oor = 0;
    for (int i = 0; i < MEMW; i++) mem[i] = 36'(i + 1);
    for (int k = 0; k < 2048; k++)
      run_op(36'h1000 + 36'(2 * k), 36'h0, 1'b0, 1'b0);
    bad_in = 0; bad_out = 0;
    for (int i = 0; i < MEMW; i++) begin
      if (i >= 'h1000 && i < 'h2000) begin
        if (mem[i] != 36'h0) bad_in++;
      end else if (mem[i] != 36'(i + 1)) bad_out++;
    end
    chk(bad_in == 0, "R9 page words cleared", 64'(bad_in), 64'd0);
    chk(bad_out == 0, "R9 outside page untouched", 64'(bad_out), 64'd0);
    chk(oor == 0, "R9 no far writes", 64'(oor), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule